// File: doc/BRIEF.md
# Prioritized Status LED Driver

This block turns a handful of slave-node health signals into the patterns shown on two status lamps, one green and one red. The inputs say whether the supply is good, whether communication with the bus master is alive, whether the node holds a valid non-zero address, whether the attached periphery reports a fault, and whether a strobe-held reset or a supply overload is in progress. When several of these conditions are present at once, the block shows only the most severe one. Each condition maps to a fixed combination of lit, dark and blinking on the two lamps.

Both outputs are sink enables for open-drain stages. A 1 means the stage pulls low and the lamp is lit. A free-running prescaler divides the system clock down to a 2.5 Hz blink with a 50% duty cycle. A soft reset darkens both lamps for as long as it is asserted, but it leaves the blink timer running, so the blink rhythm is never disturbed. A hard reset (`rstN` low) clears everything.

Top module: `status_led_driver`

## Requirements
- R1: While `rstN` is low, `greenSink` and `redSink` are both 0. After release, the blink phase starts in its dark half.
- R2: When `supplyGood` is 0, both outputs are 0 whatever the other inputs are.
- R3: When the supply is good and no fault condition is present (`holdOrOverload`=0, `faultN`=1, `addrValid`=1, `commOk`=1), `greenSink`=1 and `redSink`=0.
- R4: When the address is valid but `commOk`=0, `greenSink`=0 and `redSink`=1.
- R5: When `addrValid`=0, green blinks (it is 1 in the lit half of the blink phase) and `redSink`=1.
- R6: When `faultN`=0, the two lamps blink in antiphase: green is lit in the lit half and red is lit in the dark half.
- R7: When `holdOrOverload`=1, `greenSink`=0 and red blinks (it is 1 in the lit half).
- R8: The priority runs from highest to lowest as `holdOrOverload`, `faultN` low, `addrValid` low, `commOk` low. Only the highest active condition is shown.
- R9: The blink phase stays in each half for `CLK_HZ*10/(2*BLINK_DECIHZ)` clock cycles. The first toggle comes that many cycles after reset release, and the phase keeps alternating from then on.
- R10: The outputs reflect the inputs sampled at the previous clock edge. A change of condition does not restart the blink phase.
- R11: While `softRst` is 1, both outputs are 0 at the next edge. The blink phase keeps counting through a soft reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous hard reset, active low |
| softRst | input | 1 | Soft reset: darkens the lamps, leaves the blink timer running |
| supplyGood | input | 1 | Supply present and in range |
| commOk | input | 1 | Communication watchdog not tripped |
| addrValid | input | 1 | Stored address is consistent and non-zero |
| faultN | input | 1 | Periphery fault, active low |
| holdOrOverload | input | 1 | Strobe-held reset or supply overload present |
| greenSink | output | 1 | Green lamp sink enable, 1 = lit |
| redSink | output | 1 | Red lamp sink enable, 1 = lit |

## Verification
The hardest behaviour to observe from the ports is that the blink phase continues unbroken through soft resets and condition changes. The phase is only visible while a blinking condition is shown, and it has to be tracked from the moment reset is released. The bench shortens the half period through the clock parameters and counts clock edges from release to derive the expected phase. It then places soft resets and rapid switches between blinking conditions in the middle of a half period. A timer that restarted, or that was cleared by the soft reset, would show up as a misaligned lamp at the next blinking cycle.

// File: rtl/status_led_pkg.sv
package status_led_pkg;

  typedef enum logic [2:0] {
    MODE_DARK,
    MODE_HALT,
    MODE_FAULT,
    MODE_NOADDR,
    MODE_NOCOMM,
    MODE_RUN
  } ledMode_t;

  typedef struct packed {
    logic blinkLit;
  } blinkStrobe_t;

  typedef struct packed {
    logic green;
    logic red;
  } ledPair_t;

endpackage

// File: rtl/blink_timer.sv
module blink_timer
  import status_led_pkg::*;
#(
  parameter int HALF_CYCLES = 10_000_000
) (
  input  logic         clk,
  input  logic         rstN,
  output blinkStrobe_t strobe
);

  localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

  logic [CW-1:0] divCnt;
  logic          phase;
  logic          wrap;

  assign wrap = (divCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      phase  <= 1'b0;
    end else if (wrap) begin
      divCnt <= '0;
      phase  <= ~phase;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign strobe.blinkLit = phase;

endmodule

// File: rtl/led_mode_select.sv
module led_mode_select
  import status_led_pkg::*;
(
  input  logic     supplyGood,
  input  logic     commOk,
  input  logic     addrValid,
  input  logic     faultN,
  input  logic     holdOrOverload,
  output ledMode_t mode
);

  always_comb begin
    if (!supplyGood)         mode = MODE_DARK;
    else if (holdOrOverload) mode = MODE_HALT;
    else if (!faultN)        mode = MODE_FAULT;
    else if (!addrValid)     mode = MODE_NOADDR;
    else if (!commOk)        mode = MODE_NOCOMM;
    else                     mode = MODE_RUN;
  end

endmodule

// File: rtl/led_pattern_dp.sv
module led_pattern_dp
  import status_led_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         softRst,
  input  ledMode_t     mode,
  input  blinkStrobe_t strobe,
  output ledPair_t     leds
);

  ledPair_t nextLeds;

  always_comb begin
    unique case (mode)
      MODE_HALT:   nextLeds = '{green: 1'b0,            red: strobe.blinkLit};
      MODE_FAULT:  nextLeds = '{green: strobe.blinkLit, red: ~strobe.blinkLit};
      MODE_NOADDR: nextLeds = '{green: strobe.blinkLit, red: 1'b1};
      MODE_NOCOMM: nextLeds = '{green: 1'b0,            red: 1'b1};
      MODE_RUN:    nextLeds = '{green: 1'b1,            red: 1'b0};
      default:     nextLeds = '{green: 1'b0,            red: 1'b0};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        leds <= '0;
    else if (softRst) leds <= '0;
    else              leds <= nextLeds;
  end

endmodule

// File: rtl/status_led_driver.sv
module status_led_driver
  import status_led_pkg::*;
#(
  parameter int CLK_HZ       = 50_000_000,
  parameter int BLINK_DECIHZ = 25
) (
  input  logic clk,
  input  logic rstN,
  input  logic softRst,
  input  logic supplyGood,
  input  logic commOk,
  input  logic addrValid,
  input  logic faultN,
  input  logic holdOrOverload,
  output logic greenSink,
  output logic redSink
);

  localparam int HALF_CYCLES = (CLK_HZ * 10) / (2 * BLINK_DECIHZ);

  blinkStrobe_t strobe;
  ledMode_t     mode;
  ledPair_t     leds;

  blink_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe)
  );

  led_mode_select u_select (
    .supplyGood     (supplyGood),
    .commOk         (commOk),
    .addrValid      (addrValid),
    .faultN         (faultN),
    .holdOrOverload (holdOrOverload),
    .mode           (mode)
  );

  led_pattern_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .softRst (softRst),
    .mode    (mode),
    .strobe  (strobe),
    .leds    (leds)
  );

  assign greenSink = leds.green;
  assign redSink   = leds.red;

endmodule

// File: rtl/status_led_checker.sv
module status_led_checker (
  input logic clk,
  input logic rstN,
  input logic softRst,
  input logic supplyGood,
  input logic commOk,
  input logic addrValid,
  input logic faultN,
  input logic holdOrOverload,
  input logic greenSink,
  input logic redSink
);

  always_comb begin
    if (!rstN) begin
      AST_DARK_IN_RESET: assert (!greenSink && !redSink); // R1
    end
  end

  AST_DARK_NO_SUPPLY: assert property (@(posedge clk) disable iff (!rstN)
    !supplyGood |=> (!greenSink && !redSink)); // R2

  AST_RUN_PATTERN: assert property (@(posedge clk) disable iff (!rstN)
    (supplyGood && !softRst && !holdOrOverload && faultN && addrValid && commOk)
      |=> (greenSink && !redSink)); // R3

  AST_NOCOMM_PATTERN: assert property (@(posedge clk) disable iff (!rstN)
    (supplyGood && !softRst && !holdOrOverload && faultN && addrValid && !commOk)
      |=> (!greenSink && redSink)); // R4

  AST_NOADDR_RED_ON: assert property (@(posedge clk) disable iff (!rstN)
    (supplyGood && !softRst && !holdOrOverload && faultN && !addrValid)
      |=> redSink); // R5

  AST_FAULT_ANTIPHASE: assert property (@(posedge clk) disable iff (!rstN)
    (supplyGood && !softRst && !holdOrOverload && !faultN)
      |=> (greenSink != redSink)); // R6

  AST_HALT_GREEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (supplyGood && !softRst && holdOrOverload) |=> !greenSink); // R7

  AST_SOFT_DARK: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (!greenSink && !redSink)); // R11

endmodule

bind status_led_driver status_led_checker u_checker (
  .clk            (clk),
  .rstN           (rstN),
  .softRst        (softRst),
  .supplyGood     (supplyGood),
  .commOk         (commOk),
  .addrValid      (addrValid),
  .faultN         (faultN),
  .holdOrOverload (holdOrOverload),
  .greenSink      (greenSink),
  .redSink        (redSink)
);

// File: tb/test_status_led_driver.sv
`timescale 1ns/1ps
module test_status_led_driver;

  localparam int TB_CLK_HZ   = 200;
  localparam int TB_DECIHZ   = 25;
  localparam int HALF        = (TB_CLK_HZ * 10) / (2 * TB_DECIHZ);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic softRst = 1'b0;
  logic supplyGood = 1'b0;
  logic commOk = 1'b1;
  logic addrValid = 1'b1;
  logic faultN = 1'b1;
  logic holdOrOverload = 1'b0;
  logic greenSink, redSink;

  int vectors = 0;
  int miscompares = 0;
  int edgeCnt = 0;

  logic [1:0] expQ[$];
  string      tagQ[$];

  always #10 clk = ~clk;

  status_led_driver #(.CLK_HZ(TB_CLK_HZ), .BLINK_DECIHZ(TB_DECIHZ)) i_status_led_driver (
    .clk            (clk),
    .rstN           (rstN),
    .softRst        (softRst),
    .supplyGood     (supplyGood),
    .commOk         (commOk),
    .addrValid      (addrValid),
    .faultN         (faultN),
    .holdOrOverload (holdOrOverload),
    .greenSink      (greenSink),
    .redSink        (redSink)
  );

  always @(posedge clk) begin
    if (!rstN) edgeCnt <= 0;
    else       edgeCnt <= edgeCnt + 1;
  end

  // Expected {green, red} from the requirements, given the lit half flag
  function automatic logic [1:0] model(logic sr, logic sg, logic co, logic av,
                                       logic fn, logic ho, logic lit);
    if (sr || !sg)  return 2'b00;   // R11, R2
    if (ho)         return {1'b0, lit};   // R7
    if (!fn)        return {lit, ~lit};   // R6
    if (!av)        return {lit, 1'b1};   // R5
    if (!co)        return 2'b01;         // R4
    return 2'b10;                         // R3
  endfunction

  // Driver: applies one input set for n cycles, queues expectations
  task automatic drive(input logic sr, input logic sg, input logic co, input logic av,
                       input logic fn, input logic ho, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      softRst = sr; supplyGood = sg; commOk = co;
      addrValid = av; faultN = fn; holdOrOverload = ho;
      expQ.push_back(model(sr, sg, co, av, fn, ho, ((edgeCnt / HALF) % 2) == 1));
      tagQ.push_back(tag);
    end
  endtask

  // Monitor: compares after each edge, away from it
  always @(posedge clk) begin
    #5;
    if (expQ.size() > 0) begin
      logic [1:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      vectors++;
      if ({greenSink, redSink} !== e) begin
        miscompares++;
        $display("FAIL %s: got green=%b red=%b, expected green=%b red=%b (edge %0d)",
                 t, greenSink, redSink, e[1], e[0], edgeCnt);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    supplyGood = 1'b1;
    holdOrOverload = 1'b1;
    repeat (3) @(posedge clk);
    #5;
    vectors++;
    if ({greenSink, redSink} !== 2'b00) begin  // R1
      miscompares++;
      $display("FAIL R1: got %b%b, expected 00", greenSink, redSink);
    end
    @(negedge clk);
    rstN = 1'b1;
    // R1 and R7: red must be dark for the first half period after release
    drive(0, 1, 1, 1, 1, 1, 10, "R1_R7");
    drive(0, 1, 1, 1, 1, 0, 5,  "R3");
    drive(0, 0, 1, 1, 1, 0, 3,  "R2");
    drive(0, 0, 0, 0, 0, 1, 3,  "R2");
    drive(0, 1, 0, 1, 1, 0, 5,  "R4");
    drive(0, 1, 1, 0, 1, 0, 90, "R5_R9");
    drive(0, 1, 1, 1, 0, 0, 90, "R6_R9");
    drive(0, 1, 0, 0, 0, 0, 12, "R8");
    drive(0, 1, 1, 1, 1, 1, 90, "R7_R9");
    drive(0, 1, 0, 0, 0, 1, 12, "R8");
    drive(0, 1, 0, 0, 1, 0, 6,  "R8");
    drive(1, 1, 1, 1, 0, 0, 7,  "R11");
    drive(0, 1, 1, 1, 0, 0, 50, "R11_R9");
    for (int k = 0; k < 8; k++) begin
      drive(0, 1, 1, 1, 0, 0, 7, "R10");
      drive(0, 1, 1, 0, 1, 0, 7, "R10");
      drive(0, 1, 1, 1, 1, 1, 7, "R10");
    end
    drive(1, 1, 1, 1, 1, 1, 3,  "R11");
    drive(0, 1, 1, 1, 1, 1, 60, "R11_R10");
    drive(0, 1, 1, 1, 1, 0, 4,  "R3");
    @(posedge clk);
    #8;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule